// File: doc/BRIEF.md
# Serial-flash controller register and FIFO front-end

This block is the processor-facing half of a serial-flash controller. It decodes single-word reads and writes on a simple valid/ready register bus. Behind that bus it holds the configuration words that a transaction sequencer consumes: control, FIFO threshold, address width, command and flash address.

It buffers outgoing data in a transmit word FIFO and incoming data in a receive word FIFO. Data writes push into the transmit FIFO and the sequencer pops from it. The sequencer pushes into the receive FIFO and data reads pop from it.

Interrupt events are latched in a raw status word. Software clears them by writing ones. A per-bit mask (a mask bit of 1 hides the event) reduces them to a masked word and one interrupt line. A recovery register starts a short, self-timed soft reset that empties both FIFOs and returns the sequencer to idle. Software polls the recovery bit until it reads 0.

Top module: `flash_regif`

## Requirements
- R1: After reset the raw status, the mask, the busy flag, the interrupt line and both FIFOs are all zero or empty. The FIFO status word reads 0x0000_1006.
- R2: A write to offset 0x108 pushes one word into the 16-word transmit FIFO. The sequencer receives the words in write order on `seq_tx_data` and pops them with `seq_tx_pop`. `seq_tx_valid` is high while the FIFO holds a word.
- R3: A data write while the transmit FIFO holds 16 words is dropped and sets raw bit 2. The FIFO contents are unchanged, even if the sequencer pops in the same cycle.
- R4: A read of offset 0x108 pops the oldest word from the receive FIFO. The sequencer pushes with `seq_rx_push` and pushes are accepted while `seq_rx_ready` is high (fewer than 16 words stored).
- R5: A data read while the receive FIFO is empty returns 0 and sets raw bit 1.
- R6: The FIFO status word at 0x20 has this layout:
  - bit 0: transmit full
  - bit 1: transmit empty
  - bit 2: receive empty
  - bit 3: receive full
  - bits [12:8]: free transmit slots
  - bits [20:16]: stored receive words
- R7: Writing the clear register at 0x08 clears each raw bit whose data bit is 1. If an event sets a bit in the same cycle as it is cleared, the set wins. Reading 0x08 returns 0.
- R8: The masked word at 0x1C equals raw AND NOT mask, where the mask is at 0x04 and holds bits [7:0]. `irq` is high exactly when any masked bit is 1.
- R9: Each raw bit is set by its own event:
  - bit 0: a push that fills the receive FIFO
  - bit 3: a pop that empties the transmit FIFO
  - bit 4: `seq_done`
  - bit 5: `seq_bus_err`
  - bit 6: `seq_ser_err`
  - bit 7: `seq_dma_done`
- R10: Writing 1 to bit 0 of 0x10 raises `seq_flush` for exactly 4 cycles, starting the cycle after the write. Bit 0 of 0x10 reads 1 during that time. Afterwards both FIFOs are empty and the busy flag is 0.
- R11: A write to the command register at 0x100 sets the busy flag (bit 0 of 0x24) and gives a one-cycle `seq_start` pulse in the next cycle. `seq_done` clears the busy flag.
- R12: A write to the control register at 0x00 is ignored while the busy flag is set.
- R13: Every read returns its data one cycle after it is accepted, with `rsp_valid` high for that cycle. The threshold, address-width, command and address registers (0x0C, 0x18, 0x100, 0x104) read back what was written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Access accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | OR of the masked events |
| seq_start | output | 1 | Command written, pulse |
| seq_flush | output | 1 | Soft reset in progress |
| seq_ctrl | output | 32 | Control register |
| seq_cmd | output | 32 | Command register |
| seq_addr | output | 32 | Flash address register |
| seq_abits | output | 32 | Address-width register |
| seq_thresh | output | 32 | FIFO threshold register |
| seq_tx_pop | input | 1 | Sequencer pops a transmit word |
| seq_tx_data | output | 32 | Head of the transmit FIFO |
| seq_tx_valid | output | 1 | Transmit FIFO not empty |
| seq_rx_push | input | 1 | Sequencer pushes a receive word |
| seq_rx_data | input | 32 | Receive word |
| seq_rx_ready | output | 1 | Receive FIFO not full |
| seq_done | input | 1 | Transfer finished event |
| seq_bus_err | input | 1 | Bus error event |
| seq_ser_err | input | 1 | Serial error event |
| seq_dma_done | input | 1 | DMA finished event |

## Verification
The bench goes after the FIFO edges.

- The seventeenth transmit write must leave the FIFO untouched. A design that wrapped its write pointer would overwrite the oldest word, and the sequencer would see a wrong word.
- A read of an empty receive FIFO must return zero. A design that failed this would return stale data and never flag the underflow.

It also drives a clear and a set of the same raw bit in one cycle. A design that let the clear win would lose the event.

It counts the cycles of the soft reset and confirms that the control register stays frozen while a command runs. A wrong count would leave the sequencer half-flushed or release it early.

// File: rtl/flash_regif_pkg.sv
package flash_regif_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned EVT_N  = 8;
  localparam int unsigned LVL_W  = 5;

  // register byte offsets
  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_MASK   = 12'h004;
  localparam logic [11:0] OFS_CLR    = 12'h008;
  localparam logic [11:0] OFS_THRESH = 12'h00C;
  localparam logic [11:0] OFS_REC    = 12'h010;
  localparam logic [11:0] OFS_ABITS  = 12'h018;
  localparam logic [11:0] OFS_MSTAT  = 12'h01C;
  localparam logic [11:0] OFS_FSTAT  = 12'h020;
  localparam logic [11:0] OFS_STAT   = 12'h024;
  localparam logic [11:0] OFS_RAW    = 12'h028;
  localparam logic [11:0] OFS_CMD    = 12'h100;
  localparam logic [11:0] OFS_ADDR   = 12'h104;
  localparam logic [11:0] OFS_DATA   = 12'h108;

  // raw event bit positions
  localparam int unsigned EV_RX_FULL  = 0;
  localparam int unsigned EV_RX_UDF   = 1;
  localparam int unsigned EV_TX_OVF   = 2;
  localparam int unsigned EV_TX_EMPTY = 3;
  localparam int unsigned EV_DONE     = 4;
  localparam int unsigned EV_BUS_ERR  = 5;
  localparam int unsigned EV_SER_ERR  = 6;
  localparam int unsigned EV_DMA_DONE = 7;

  function automatic logic [EVT_N-1:0] masked_events(
    input logic [EVT_N-1:0] raw, input logic [EVT_N-1:0] mask);
    return raw & ~mask;
  endfunction

  function automatic logic [EVT_N-1:0] w1c_update(
    input logic [EVT_N-1:0] raw, input logic [EVT_N-1:0] clr,
    input logic [EVT_N-1:0] set);
    return (raw & ~clr) | set;
  endfunction

  function automatic logic [WORD_W-1:0] fifo_status_word(
    input logic tx_full, input logic tx_empty,
    input logic rx_empty, input logic rx_full,
    input logic [LVL_W-1:0] tx_free, input logic [LVL_W-1:0] rx_used);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[0]     = tx_full;
    w[1]     = tx_empty;
    w[2]     = rx_empty;
    w[3]     = rx_full;
    w[12:8]  = tx_free;
    w[20:16] = rx_used;
    return w;
  endfunction

endpackage

// File: rtl/flash_word_fifo.sv
module flash_word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  // DEPTH is a power of two so the pointers wrap on their own
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign dout    = mem[rd_ptr];
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/flash_irq_bank.sv
module flash_irq_bank
  import flash_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] set_vec,
  input  logic             clr_we,
  input  logic [EVT_N-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [EVT_N-1:0] mask_din,
  output logic [EVT_N-1:0] raw,
  output logic [EVT_N-1:0] mask,
  output logic [EVT_N-1:0] masked,
  output logic             irq
);
  logic [EVT_N-1:0] raw_q, mask_q, clr_eff;

  assign clr_eff = clr_we ? clr_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= w1c_update(raw_q, clr_eff, set_vec);
      if (mask_we) mask_q <= mask_din;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = masked_events(raw_q, mask_q);
  assign irq    = |masked;

endmodule

// File: rtl/flash_soft_reset.sv
module flash_soft_reset #(
  parameter int unsigned CYCLES = 4,
  localparam int unsigned CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  logic [CW-1:0] cnt_q;

  assign active = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start && !active) cnt_q <= CW'(CYCLES);
    else if (active)           cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/flash_regif.sv
module flash_regif
  import flash_regif_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned RST_CYCLES = 4,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              irq,
  output logic              seq_start,
  output logic              seq_flush,
  output logic [WORD_W-1:0] seq_ctrl,
  output logic [WORD_W-1:0] seq_cmd,
  output logic [WORD_W-1:0] seq_addr,
  output logic [WORD_W-1:0] seq_abits,
  output logic [WORD_W-1:0] seq_thresh,
  input  logic              seq_tx_pop,
  output logic [WORD_W-1:0] seq_tx_data,
  output logic              seq_tx_valid,
  input  logic              seq_rx_push,
  input  logic [WORD_W-1:0] seq_rx_data,
  output logic              seq_rx_ready,
  input  logic              seq_done,
  input  logic              seq_bus_err,
  input  logic              seq_ser_err,
  input  logic              seq_dma_done
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  // access decode
  logic wr_acc, rd_acc;
  logic hit_ctrl, hit_mask, hit_clr, hit_thresh, hit_rec, hit_abits;
  logic hit_cmd, hit_addr, hit_data;

  assign req_ready  = 1'b1;
  assign wr_acc     = req_valid & req_write;
  assign rd_acc     = req_valid & ~req_write;
  assign hit_ctrl   = (req_addr == ADDR_W'(OFS_CTRL));
  assign hit_mask   = (req_addr == ADDR_W'(OFS_MASK));
  assign hit_clr    = (req_addr == ADDR_W'(OFS_CLR));
  assign hit_thresh = (req_addr == ADDR_W'(OFS_THRESH));
  assign hit_rec    = (req_addr == ADDR_W'(OFS_REC));
  assign hit_abits  = (req_addr == ADDR_W'(OFS_ABITS));
  assign hit_cmd    = (req_addr == ADDR_W'(OFS_CMD));
  assign hit_addr   = (req_addr == ADDR_W'(OFS_ADDR));
  assign hit_data   = (req_addr == ADDR_W'(OFS_DATA));

  // soft reset
  logic rec_active;

  flash_soft_reset #(.CYCLES(RST_CYCLES)) u_srst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (wr_acc & hit_rec & req_wdata[0]),
    .active (rec_active)
  );
  assign seq_flush = rec_active;

  // FIFOs
  logic [WORD_W-1:0] tx_head, rx_head;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_push, tx_pop, rx_push, rx_pop;

  assign tx_push = wr_acc & hit_data;
  assign tx_pop  = seq_tx_pop;
  assign rx_push = seq_rx_push;
  assign rx_pop  = rd_acc & hit_data;

  flash_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk (clk), .rst_n (rst_n), .flush (rec_active),
    .push (tx_push), .din (req_wdata), .pop (tx_pop),
    .dout (tx_head), .count (tx_cnt), .full (tx_full), .empty (tx_empty)
  );

  flash_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk (clk), .rst_n (rst_n), .flush (rec_active),
    .push (rx_push), .din (seq_rx_data), .pop (rx_pop),
    .dout (rx_head), .count (rx_cnt), .full (rx_full), .empty (rx_empty)
  );

  assign seq_tx_data  = tx_head;
  assign seq_tx_valid = ~tx_empty;
  assign seq_rx_ready = ~rx_full;

  // named events
  logic tx_ovf_ev, rx_udf_ev, rx_full_ev, tx_empty_ev;

  assign tx_ovf_ev   = tx_push & tx_full;
  assign rx_udf_ev   = rx_pop & rx_empty;
  assign rx_full_ev  = rx_push & ~rx_full & ~rec_active & ~(rx_pop & ~rx_empty)
                     & (rx_cnt == CNT_W'(FIFO_DEPTH - 1));
  assign tx_empty_ev = tx_pop & ~tx_empty & ~rec_active & ~(tx_push & ~tx_full)
                     & (tx_cnt == CNT_W'(1));

  // interrupts
  logic [EVT_N-1:0] ev_set, irq_raw, irq_mask, irq_masked;

  always_comb begin
    ev_set              = '0;
    ev_set[EV_RX_FULL]  = rx_full_ev;
    ev_set[EV_RX_UDF]   = rx_udf_ev;
    ev_set[EV_TX_OVF]   = tx_ovf_ev;
    ev_set[EV_TX_EMPTY] = tx_empty_ev;
    ev_set[EV_DONE]     = seq_done;
    ev_set[EV_BUS_ERR]  = seq_bus_err;
    ev_set[EV_SER_ERR]  = seq_ser_err;
    ev_set[EV_DMA_DONE] = seq_dma_done;
  end

  flash_irq_bank u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (ev_set),
    .clr_we   (wr_acc & hit_clr),
    .clr_vec  (req_wdata[EVT_N-1:0]),
    .mask_we  (wr_acc & hit_mask),
    .mask_din (req_wdata[EVT_N-1:0]),
    .raw      (irq_raw),
    .mask     (irq_mask),
    .masked   (irq_masked),
    .irq      (irq)
  );

  // configuration registers and busy flag
  logic [WORD_W-1:0] ctrl_q, thresh_q, abits_q, cmd_q, addr_q;
  logic              busy_q, start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      thresh_q <= '0;
      abits_q  <= '0;
      cmd_q    <= '0;
      addr_q   <= '0;
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      if (wr_acc && hit_ctrl && !busy_q) ctrl_q   <= req_wdata;
      if (wr_acc && hit_thresh)          thresh_q <= req_wdata;
      if (wr_acc && hit_abits)           abits_q  <= req_wdata;
      if (wr_acc && hit_cmd)             cmd_q    <= req_wdata;
      if (wr_acc && hit_addr)            addr_q   <= req_wdata;
      start_q <= wr_acc & hit_cmd & ~rec_active;
      if (rec_active)              busy_q <= 1'b0;
      else if (wr_acc && hit_cmd)  busy_q <= 1'b1;
      else if (seq_done)           busy_q <= 1'b0;
    end
  end

  assign seq_start  = start_q;
  assign seq_ctrl   = ctrl_q;
  assign seq_cmd    = cmd_q;
  assign seq_addr   = addr_q;
  assign seq_abits  = abits_q;
  assign seq_thresh = thresh_q;

  // read path
  logic [WORD_W-1:0] rd_val, fstat;
  logic [WORD_W-1:0] rsp_q;
  logic              rsp_v_q;

  assign fstat = fifo_status_word(tx_full, tx_empty, rx_empty, rx_full,
                                  LVL_W'(CNT_W'(FIFO_DEPTH) - tx_cnt),
                                  LVL_W'(rx_cnt));

  always_comb begin
    rd_val = '0;
    case (req_addr)
      ADDR_W'(OFS_CTRL):   rd_val = ctrl_q;
      ADDR_W'(OFS_MASK):   rd_val = WORD_W'(irq_mask);
      ADDR_W'(OFS_THRESH): rd_val = thresh_q;
      ADDR_W'(OFS_REC):    rd_val = WORD_W'(rec_active);
      ADDR_W'(OFS_ABITS):  rd_val = abits_q;
      ADDR_W'(OFS_MSTAT):  rd_val = WORD_W'(irq_masked);
      ADDR_W'(OFS_FSTAT):  rd_val = fstat;
      ADDR_W'(OFS_STAT):   rd_val = WORD_W'(busy_q);
      ADDR_W'(OFS_RAW):    rd_val = WORD_W'(irq_raw);
      ADDR_W'(OFS_CMD):    rd_val = cmd_q;
      ADDR_W'(OFS_ADDR):   rd_val = addr_q;
      ADDR_W'(OFS_DATA):   rd_val = rx_empty ? '0 : rx_head;
      default:             rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      rsp_v_q <= rd_acc;
      rsp_q   <= rd_acc ? rd_val : '0;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_q;

endmodule

// File: rtl/flash_regif_chk.sv
module flash_regif_chk
  import flash_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              wbit0,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic              irq,
  input logic              seq_flush,
  input logic              seq_tx_valid,
  input logic              seq_rx_ready,
  input logic              seq_start,
  input logic              busy,
  input logic              tx_ovf_ev,
  input logic              rx_udf_ev,
  input logic [EVT_N-1:0]  raw,
  input logic [EVT_N-1:0]  mask
);
  AST_REC_STARTS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(OFS_REC) && wbit0 && !seq_flush)
    |=> seq_flush); // R10

  AST_FLUSH_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_flush) |-> (!seq_tx_valid && seq_rx_ready && !busy)); // R10

  AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf_ev |=> raw[EV_TX_OVF]); // R3

  AST_UDF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_udf_ev |=> (rsp_valid && rsp_rdata == '0 && raw[EV_RX_UDF])); // R5

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq); // R8

  AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> busy); // R11

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write)); // R13

endmodule

bind flash_regif flash_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .wbit0        (req_wdata[0]),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .irq          (irq),
  .seq_flush    (seq_flush),
  .seq_tx_valid (seq_tx_valid),
  .seq_rx_ready (seq_rx_ready),
  .seq_start    (seq_start),
  .busy         (busy_q),
  .tx_ovf_ev    (tx_ovf_ev),
  .rx_udf_ev    (rx_udf_ev),
  .raw          (irq_raw),
  .mask         (irq_mask)
);

// File: tb/tb_flash_regif.sv
`timescale 1ns/1ps
module tb_flash_regif;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq, seq_start, seq_flush;
  logic [31:0] rsp_rdata, seq_ctrl, seq_cmd, seq_addr, seq_abits, seq_thresh;
  logic        seq_tx_pop = 1'b0, seq_rx_push = 1'b0;
  logic [31:0] seq_rx_data = '0, seq_tx_data;
  logic        seq_tx_valid, seq_rx_ready;
  logic        seq_done = 1'b0, seq_bus_err = 1'b0, seq_ser_err = 1'b0, seq_dma_done = 1'b0;

  always #2 clk = ~clk;

  flash_regif dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .irq (irq),
    .seq_start (seq_start), .seq_flush (seq_flush),
    .seq_ctrl (seq_ctrl), .seq_cmd (seq_cmd), .seq_addr (seq_addr),
    .seq_abits (seq_abits), .seq_thresh (seq_thresh),
    .seq_tx_pop (seq_tx_pop), .seq_tx_data (seq_tx_data), .seq_tx_valid (seq_tx_valid),
    .seq_rx_push (seq_rx_push), .seq_rx_data (seq_rx_data), .seq_rx_ready (seq_rx_ready),
    .seq_done (seq_done), .seq_bus_err (seq_bus_err), .seq_ser_err (seq_ser_err),
    .seq_dma_done (seq_dma_done)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_tx[$];
  logic [31:0] m_rx[$];
  logic [7:0]  m_raw, m_mask;
  logic [31:0] m_ctrl, m_cmd, m_addr, m_abits, m_thr, m_rspd;
  int          m_rcnt;
  bit          m_busy, m_start, m_rspv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx.delete(); m_rx.delete();
      m_raw = 0; m_mask = 0; m_ctrl = 0; m_cmd = 0; m_addr = 0; m_abits = 0; m_thr = 0;
      m_rcnt = 0; m_busy = 0; m_start = 0; m_rspv = 0; m_rspd = 0;
    end else begin
      bit wr, rd, fl, tpush, tovf, tpop, rpush, rpop, rudf;
      int ts, rs;
      logic [7:0]  setv;
      logic [31:0] rdv;
      wr = req_valid && req_write;
      rd = req_valid && !req_write;
      fl = (m_rcnt != 0);
      ts = m_tx.size();
      rs = m_rx.size();
      setv = 0;
      rdv = 0;
      case (req_addr)
        12'h000: rdv = m_ctrl;
        12'h004: rdv = {24'd0, m_mask};
        12'h00C: rdv = m_thr;
        12'h010: rdv = {31'd0, fl};
        12'h018: rdv = m_abits;
        12'h01C: rdv = {24'd0, m_raw & ~m_mask};
        12'h020: rdv = (16 - ts) * 256 + rs * 65536 + (ts == 16 ? 1 : 0)
                     + (ts == 0 ? 2 : 0) + (rs == 0 ? 4 : 0) + (rs == 16 ? 8 : 0);
        12'h024: rdv = {31'd0, m_busy};
        12'h028: rdv = {24'd0, m_raw};
        12'h100: rdv = m_cmd;
        12'h104: rdv = m_addr;
        12'h108: rdv = (rs > 0) ? m_rx[0] : 32'd0;
        default: rdv = 0;
      endcase
      tpush = wr && req_addr == 12'h108 && ts < 16;
      tovf  = wr && req_addr == 12'h108 && ts == 16;
      tpop  = seq_tx_pop && ts > 0;
      rpush = seq_rx_push && rs < 16;
      rpop  = rd && req_addr == 12'h108 && rs > 0;
      rudf  = rd && req_addr == 12'h108 && rs == 0;
      if (fl) begin
        m_tx.delete(); m_rx.delete();
      end else begin
        if (tpop) void'(m_tx.pop_front());
        if (tpush) m_tx.push_back(req_wdata);
        if (tpop && ts == 1 && !tpush) setv[3] = 1;
        if (rpop) void'(m_rx.pop_front());
        if (rpush) m_rx.push_back(seq_rx_data);
        if (rpush && rs == 15 && !rpop) setv[0] = 1;
      end
      setv[1] = rudf;
      setv[2] = tovf;
      setv[4] = seq_done;
      setv[5] = seq_bus_err;
      setv[6] = seq_ser_err;
      setv[7] = seq_dma_done;
      if (wr && req_addr == 12'h008) m_raw = m_raw & ~req_wdata[7:0];
      m_raw = m_raw | setv;
      if (wr && req_addr == 12'h004) m_mask = req_wdata[7:0];
      if (wr && req_addr == 12'h000 && !m_busy) m_ctrl = req_wdata;
      if (wr && req_addr == 12'h00C) m_thr = req_wdata;
      if (wr && req_addr == 12'h018) m_abits = req_wdata;
      if (wr && req_addr == 12'h100) m_cmd = req_wdata;
      if (wr && req_addr == 12'h104) m_addr = req_wdata;
      m_start = wr && req_addr == 12'h100 && !fl;
      if (fl) m_busy = 0;
      else if (wr && req_addr == 12'h100) m_busy = 1;
      else if (seq_done) m_busy = 0;
      if (fl) m_rcnt = m_rcnt - 1;
      else if (wr && req_addr == 12'h010 && req_wdata[0]) m_rcnt = 4;
      m_rspv = rd;
      m_rspd = rd ? rdv : 32'd0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int cyc_checks = 0, cyc_fails = 0;

  task automatic cyc_cmp(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
    cyc_checks++;
    if (!ok) begin
      cyc_fails++;
      $display("FAIL %s cycle compare at %0t: act=%h exp=%h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      cyc_cmp(irq == |(m_raw & ~m_mask), "R8 irq", {31'd0, irq}, {31'd0, |(m_raw & ~m_mask)});
      cyc_cmp(seq_tx_valid == (m_tx.size() > 0), "R2 tx_valid", {31'd0, seq_tx_valid},
              {31'd0, m_tx.size() > 0});
      if (m_tx.size() > 0)
        cyc_cmp(seq_tx_data == m_tx[0], "R2 tx_data", seq_tx_data, m_tx[0]);
      cyc_cmp(seq_rx_ready == (m_rx.size() < 16), "R4 rx_ready", {31'd0, seq_rx_ready},
              {31'd0, m_rx.size() < 16});
      cyc_cmp(seq_flush == (m_rcnt != 0), "R10 flush", {31'd0, seq_flush}, {31'd0, m_rcnt != 0});
      cyc_cmp(seq_start == m_start, "R11 start", {31'd0, seq_start}, {31'd0, m_start});
      cyc_cmp(rsp_valid == m_rspv, "R13 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rspv});
      if (m_rspv) cyc_cmp(rsp_rdata == m_rspd, "R13 rsp_rdata", rsp_rdata, m_rspd);
      cyc_cmp(seq_ctrl == m_ctrl, "R12 ctrl", seq_ctrl, m_ctrl);
      cyc_cmp(seq_cmd == m_cmd, "R13 cmd", seq_cmd, m_cmd);
    end
  end

  // ---------------- directed stimulus ----------------
  int dir_checks = 0, dir_fails = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    dir_checks++;
    if (act !== exp) begin
      dir_fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic tx_pop1();
    @(negedge clk); seq_tx_pop = 1;
    @(negedge clk); seq_tx_pop = 0;
  endtask

  task automatic rx_push1(input logic [31:0] d);
    @(negedge clk); seq_rx_push = 1; seq_rx_data = d;
    @(negedge clk); seq_rx_push = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); seq_done = 1;
    @(negedge clk); seq_done = 0;
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_rd(12'h020, v); check("R1 fifo status after reset", v, 32'h0000_1006);
    bus_rd(12'h028, v); check("R1 raw after reset", v, 32'h0);
    bus_rd(12'h024, v); check("R1 busy after reset", v, 32'h0);
    check("R1 irq after reset", {31'd0, irq}, 32'h0);

    // R2 / R6 transmit order and levels
    bus_wr(12'h108, 32'hA000_0001);
    bus_wr(12'h108, 32'hA000_0002);
    bus_wr(12'h108, 32'hA000_0003);
    bus_rd(12'h020, v); check("R6 status with 3 tx words", v, 32'h0000_0D04);
    check("R2 tx head first", seq_tx_data, 32'hA000_0001);
    tx_pop1();
    check("R2 tx head second", seq_tx_data, 32'hA000_0002);
    tx_pop1();
    check("R2 tx head third", seq_tx_data, 32'hA000_0003);
    tx_pop1();
    bus_rd(12'h028, v); check("R9 tx-empty event", v, 32'h08);

    // R7 clear all
    bus_wr(12'h008, 32'hFFFF_FFFF);
    bus_rd(12'h028, v); check("R7 clear all", v, 32'h0);

    // R3 overflow
    for (int i = 0; i < 17; i++) bus_wr(12'h108, 32'h0000_0200 + i);
    bus_rd(12'h028, v); check("R3 overflow flag", v, 32'h04);
    bus_rd(12'h020, v); check("R6 status tx full", v, 32'h0000_0005);
    for (int i = 0; i < 16; i++) begin
      check("R3 tx contents kept", seq_tx_data, 32'h0000_0200 + i);
      tx_pop1();
    end
    check("R3 dropped word absent", {31'd0, seq_tx_valid}, 32'h0);

    // R8 masking
    bus_wr(12'h004, 32'h0000_00FB);
    bus_rd(12'h01C, v); check("R8 masked word", v, 32'h04);
    check("R8 irq on", {31'd0, irq}, 32'h1);
    bus_wr(12'h004, 32'h0000_00FF);
    check("R8 irq off when all masked", {31'd0, irq}, 32'h0);
    bus_wr(12'h004, 32'h0);
    bus_wr(12'h008, 32'hFFFF_FFFF);
    check("R7 irq cleared", {31'd0, irq}, 32'h0);

    // R4 / R5 receive path
    for (int i = 0; i < 16; i++) rx_push1(32'h0000_0300 + i);
    bus_rd(12'h020, v); check("R6 status rx full", v, 32'h0010_100A);
    bus_rd(12'h028, v); check("R9 rx-full event", v, 32'h01);
    for (int i = 0; i < 16; i++) begin
      bus_rd(12'h108, v); check("R4 rx order", v, 32'h0000_0300 + i);
    end
    bus_rd(12'h108, v); check("R5 empty read is zero", v, 32'h0);
    bus_rd(12'h028, v); check("R5 underflow flag", v, 32'h03);
    bus_wr(12'h008, 32'hFFFF_FFFF);

    // R7 set wins over clear
    done_pulse();
    bus_rd(12'h028, v); check("R9 done event", v, 32'h10);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 12'h008; req_wdata = 32'h10; seq_done = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; seq_done = 0;
    bus_rd(12'h028, v); check("R7 set wins", v, 32'h10);
    bus_wr(12'h008, 32'h10);
    bus_rd(12'h028, v); check("R7 single-bit clear", v, 32'h0);
    bus_rd(12'h008, v); check("R7 clear reads zero", v, 32'h0);

    // R11 / R12 busy and control lock
    bus_wr(12'h000, 32'h2);
    bus_rd(12'h000, v); check("R12 ctrl write idle", v, 32'h2);
    bus_wr(12'h100, 32'h0003_0005);
    bus_rd(12'h024, v); check("R11 busy set", v, 32'h1);
    bus_wr(12'h000, 32'h5);
    bus_rd(12'h000, v); check("R12 ctrl locked", v, 32'h2);
    done_pulse();
    bus_rd(12'h024, v); check("R11 busy cleared", v, 32'h0);
    bus_wr(12'h000, 32'h5);
    bus_rd(12'h000, v); check("R12 ctrl after done", v, 32'h5);
    bus_wr(12'h008, 32'hFFFF_FFFF);

    // R10 soft reset
    bus_wr(12'h108, 32'h1);
    bus_wr(12'h108, 32'h2);
    rx_push1(32'h11);
    rx_push1(32'h12);
    bus_wr(12'h100, 32'h7);
    bus_wr(12'h010, 32'h1);
    n = 0;
    while (seq_flush && n < 20) begin
      n++;
      @(negedge clk);
    end
    check("R10 flush length", n, 32'd4);
    bus_rd(12'h010, v); check("R10 recovery done", v, 32'h0);
    bus_rd(12'h020, v); check("R10 fifos flushed", v, 32'h0000_1006);
    bus_rd(12'h024, v); check("R10 busy cleared", v, 32'h0);
    bus_wr(12'h010, 32'h1);
    bus_rd(12'h010, v); check("R10 recovery reads one", v, 32'h1);
    repeat (6) @(negedge clk);

    // R13 readback and unmapped
    bus_wr(12'h00C, 32'h0000_000F);
    bus_rd(12'h00C, v); check("R13 threshold readback", v, 32'h0000_000F);
    bus_wr(12'h018, 32'h2);
    bus_rd(12'h018, v); check("R13 abits readback", v, 32'h2);
    bus_wr(12'h104, 32'h00AB_CDEF);
    bus_rd(12'h104, v); check("R13 address readback", v, 32'h00AB_CDEF);
    bus_rd(12'h0FC, v); check("R13 unmapped zero", v, 32'h0);

    // R9 external events
    bus_wr(12'h008, 32'hFFFF_FFFF);
    @(negedge clk); seq_bus_err = 1;  @(negedge clk); seq_bus_err = 0;
    @(negedge clk); seq_ser_err = 1;  @(negedge clk); seq_ser_err = 0;
    @(negedge clk); seq_dma_done = 1; @(negedge clk); seq_dma_done = 0;
    bus_rd(12'h028, v); check("R9 external events", v, 32'hE0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", dir_checks + cyc_checks, dir_fails + cyc_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", dir_checks + cyc_checks + 1,
               dir_fails + cyc_fails + 1);
      $finish;
    end
  end

endmodule